// File: doc/BRIEF.md
# Wait-State Word Memory Slave for AHB-Lite

This block is a single-port memory target on an AHB-Lite bus. It keeps a small array of data words and serves reads and writes of bytes, halfwords and words from it. Each transfer follows the pipelined pattern of the bus. The address and control of a transfer are registered at the clock edge where the transfer is accepted. The data of that transfer is moved during the following cycle or cycles, while the master already presents the next transfer's address.

The number of wait states is set per transfer through the `hwait_cfg` input, which is sampled together with the address. While a data phase is being stretched, the block holds `hreadyout` low. The master's view of `hready` then keeps the next address phase waiting, and that address phase is captured only on the edge where the current data phase ends. Burst type, protection and lock qualifiers are accepted and have no effect. The response is always OKAY.

Top module: `ahbw_mem_slave`

## Requirements
- R1: After reset `hreadyout` is high, `hresp` is low and no data phase is pending.
- R2: A transfer is accepted only on an edge where `hsel` and `hready` are both high and `htrans` is NONSEQ (2'b10) or SEQ (2'b11). A write presented with `hsel` low, or with `hready` low, changes no memory word and starts no wait states.
- R3: IDLE (2'b00) and BUSY (2'b01) transfers get a zero-wait OKAY reply in the next cycle and leave memory unchanged.
- R4: The value on `hwait_cfg` at the accepting edge gives the wait-state count N. `hreadyout` is low for exactly N cycles, starting the cycle after acceptance, and is high in the cycle after those.
- R5: With N = 0 the data phase lasts one cycle and `hreadyout` never drops.
- R6: A word write (`hsize` 3'b010, `hwrite` high) stores the `hwdata` value present in the cycle where `hreadyout` is high at the end of the data phase.
- R7: A byte write (`hsize` 3'b000) changes only bits 8*k+7..8*k, where k = `haddr[1:0]`. A halfword write (`hsize` 3'b001) changes only bits 16*h+15..16*h, where h = `haddr[1]`. All other bits of the word keep their value, so lanes are in little-endian order.
- R8: A read returns the whole word at word index `haddr[7:2]` on `hrdata` in the cycle where `hreadyout` is high at the end of its data phase, and it includes the effect of a write completed in the previous transfer.
- R9: `hrdata` does not change while `hreadyout` is low.
- R10: `hresp` is low in every cycle.
- R11: Address and control presented while a data phase is being stretched are taken at the edge that ends that data phase, so back-to-back transfers with different wait counts each see their own count.
- R12: `hburst`, `hprot` and `hmastlock` have no effect on stored data, read data or timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| hclk | input | 1 | Bus clock, rising edge |
| hresetn | input | 1 | Asynchronous active-low reset |
| hsel | input | 1 | Slave select |
| haddr | input | ADDR_W | Byte address; the low 8 bits are decoded by default |
| htrans | input | 2 | Transfer type: IDLE, BUSY, NONSEQ, SEQ |
| hwrite | input | 1 | High for a write |
| hsize | input | 3 | Access size: byte, halfword, word |
| hburst | input | 3 | Burst type, ignored |
| hprot | input | 4 | Protection attributes, ignored |
| hmastlock | input | 1 | Locked sequence flag, ignored |
| hwdata | input | DATA_W | Write data, valid in the data phase |
| hready | input | 1 | Bus-wide ready, high when the previous data phase ends |
| hwait_cfg | input | WAIT_W | Wait states for the transfer in its address phase |
| hrdata | output | DATA_W | Read data |
| hreadyout | output | 1 | Low while this slave stretches a data phase |
| hresp | output | 1 | Transfer response, always OKAY (low) |

## Verification
The stimulus first fills every word with zero-wait word writes. It then runs a long mix of random sizes, lanes, directions, transfer types, select levels and wait counts from 0 to 15, which separates a correct lane strobe from a shifted or widened one and a correct stall length from one that is off by one cycle. Directed sequences put a long stall directly before a short one, which shows whether the next address phase is captured early. They also drive `hready` low from outside while a write is presented, which shows whether the ready gate on capture works, and they issue IDLE, BUSY and deselected writes followed by reads, which shows whether any of them reaches memory. Read-back after each byte and halfword write shows whether neighbouring lanes were disturbed.

// File: rtl/ahbw_pkg.sv
package ahbw_pkg;

  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } trans_e;

  localparam logic [2:0] SZ_BYTE = 3'b000;
  localparam logic [2:0] SZ_HALF = 3'b001;
  localparam logic [2:0] SZ_WORD = 3'b010;

endpackage

// File: rtl/ahbw_aphase.sv
module ahbw_aphase #(
  parameter int LOW_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hsel,
  input  logic             hready,
  input  logic [1:0]       htrans,
  input  logic             hwrite,
  input  logic [2:0]       hsize,
  input  logic [LOW_W-1:0] addr_lo,
  output logic             accept,
  output logic             dp_valid,
  output logic             dp_write,
  output logic [2:0]       dp_size,
  output logic [LOW_W-1:0] dp_addr
);
  import ahbw_pkg::*;

  logic             valid_n;
  logic             write_n;
  logic [2:0]       size_n;
  logic [LOW_W-1:0] addr_n;

  always_comb begin
    accept  = hsel && hready &&
              ((htrans == TR_NONSEQ) || (htrans == TR_SEQ));
    valid_n = dp_valid;
    write_n = dp_write;
    size_n  = dp_size;
    addr_n  = dp_addr;
    if (hready) begin
      valid_n = accept;
      if (accept) begin
        write_n = hwrite;
        size_n  = hsize;
        addr_n  = addr_lo;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dp_valid <= 1'b0;
      dp_write <= 1'b0;
      dp_size  <= SZ_WORD;
      dp_addr  <= '0;
    end else begin
      dp_valid <= valid_n;
      dp_write <= write_n;
      dp_size  <= size_n;
      dp_addr  <= addr_n;
    end
  end

endmodule

// File: rtl/ahbw_waitgen.sv
module ahbw_waitgen #(
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hready,
  input  logic              accept,
  input  logic [WAIT_W-1:0] cfg,
  input  logic              dp_valid,
  output logic              stall
);

  logic [WAIT_W-1:0] cnt;
  logic [WAIT_W-1:0] cnt_n;

  always_comb begin
    cnt_n = cnt;
    if (hready) begin
      cnt_n = accept ? cfg : '0;
    end else if (cnt != '0) begin
      cnt_n = cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_n;
  end

  assign stall = dp_valid && (cnt != '0);

endmodule

// File: rtl/ahbw_lanes.sv
module ahbw_lanes #(
  parameter int BYTES = 4,
  localparam int OFF_W = $clog2(BYTES)
) (
  input  logic [OFF_W-1:0] off,
  input  logic [2:0]       size,
  output logic [BYTES-1:0] strobe
);

  always_comb begin
    for (int b = 0; b < BYTES; b++) begin
      if (int'(size) >= OFF_W) begin
        strobe[b] = 1'b1;
      end else begin
        strobe[b] = ((OFF_W'(b) >> size) == (off >> size));
      end
    end
  end

endmodule

// File: rtl/ahbw_store.sv
module ahbw_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 64,
  localparam int BYTES = DATA_W / 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [BYTES-1:0]  strobe,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      for (int b = 0; b < BYTES; b++) begin
        if (strobe[b]) mem[idx][8*b +: 8] <= wdata[8*b +: 8];
      end
    end
  end

  assign rdata = mem[idx];

endmodule

// File: rtl/ahbw_mem_slave.sv
module ahbw_mem_slave #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 64,
  parameter int WAIT_W = 4
) (
  input  logic              hclk,
  input  logic              hresetn,
  input  logic              hsel,
  input  logic [ADDR_W-1:0] haddr,
  input  logic [1:0]        htrans,
  input  logic              hwrite,
  input  logic [2:0]        hsize,
  input  logic [2:0]        hburst,
  input  logic [3:0]        hprot,
  input  logic              hmastlock,
  input  logic [DATA_W-1:0] hwdata,
  input  logic              hready,
  input  logic [WAIT_W-1:0] hwait_cfg,
  output logic [DATA_W-1:0] hrdata,
  output logic              hreadyout,
  output logic              hresp
);

  localparam int BYTES = DATA_W / 8;
  localparam int OFF_W = $clog2(BYTES);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int LOW_W = OFF_W + IDX_W;

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync;
  logic       rst_n;

  always_ff @(posedge hclk or negedge hresetn) begin
    if (!hresetn) rst_sync <= 2'b00;
    else          rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n = rst_sync[1];

  logic             accept;
  logic             dp_valid;
  logic             dp_write;
  logic [2:0]       dp_size;
  logic [LOW_W-1:0] dp_addr;
  logic             stall;
  logic [BYTES-1:0] strobe;
  logic [DATA_W-1:0] mem_rdata;
  logic             mem_we;

  ahbw_aphase #(.LOW_W(LOW_W)) u_aphase (
    .clk      (hclk),
    .rst_n    (rst_n),
    .hsel     (hsel),
    .hready   (hready),
    .htrans   (htrans),
    .hwrite   (hwrite),
    .hsize    (hsize),
    .addr_lo  (haddr[LOW_W-1:0]),
    .accept   (accept),
    .dp_valid (dp_valid),
    .dp_write (dp_write),
    .dp_size  (dp_size),
    .dp_addr  (dp_addr)
  );

  ahbw_waitgen #(.WAIT_W(WAIT_W)) u_wait (
    .clk      (hclk),
    .rst_n    (rst_n),
    .hready   (hready),
    .accept   (accept),
    .cfg      (hwait_cfg),
    .dp_valid (dp_valid),
    .stall    (stall)
  );

  ahbw_lanes #(.BYTES(BYTES)) u_lanes (
    .off    (dp_addr[OFF_W-1:0]),
    .size   (dp_size),
    .strobe (strobe)
  );

  assign mem_we = dp_valid && dp_write && !stall;

  ahbw_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk    (hclk),
    .we     (mem_we),
    .strobe (strobe),
    .idx    (dp_addr[LOW_W-1:OFF_W]),
    .wdata  (hwdata),
    .rdata  (mem_rdata)
  );

  assign hrdata    = (dp_valid && !dp_write) ? mem_rdata : '0;
  assign hreadyout = !stall;
  assign hresp     = 1'b0;

  // qualifiers accepted on the bus but not acted upon
  logic unused_ign;
  assign unused_ign = ^{hburst, hprot, hmastlock, haddr[ADDR_W-1:LOW_W]};

endmodule

// File: rtl/ahbw_chk.sv
module ahbw_chk #(
  parameter int DATA_W = 32,
  parameter int WAIT_W = 4
) (
  input logic              hclk,
  input logic              hresetn,
  input logic              hsel,
  input logic              hready,
  input logic [1:0]        htrans,
  input logic [WAIT_W-1:0] hwait_cfg,
  input logic              hreadyout,
  input logic [DATA_W-1:0] hrdata
);

  logic              pend;
  logic [WAIT_W-1:0] left;
  logic              acc;

  assign acc = hsel && hready && htrans[1];

  always_ff @(posedge hclk or negedge hresetn) begin
    if (!hresetn) begin
      pend <= 1'b0;
      left <= '0;
    end else if (hreadyout) begin
      pend <= acc;
      left <= acc ? hwait_cfg : '0;
    end else if (left != '0) begin
      left <= left - 1'b1;
    end
  end

  AST_STALL_LOW: assert property (@(posedge hclk) disable iff (!hresetn)
    (pend && left != '0) |-> !hreadyout); // R4

  AST_STALL_END: assert property (@(posedge hclk) disable iff (!hresetn)
    (pend && left == '0) |-> hreadyout); // R5

  AST_NO_PEND_READY: assert property (@(posedge hclk) disable iff (!hresetn)
    !pend |-> hreadyout); // R3

  AST_RDATA_HOLD: assert property (@(posedge hclk) disable iff (!hresetn)
    !hreadyout |=> $stable(hrdata)); // R9

endmodule

bind ahbw_mem_slave ahbw_chk #(.DATA_W(DATA_W), .WAIT_W(WAIT_W)) u_chk (
  .hclk      (hclk),
  .hresetn   (hresetn),
  .hsel      (hsel),
  .hready    (hready),
  .htrans    (htrans),
  .hwait_cfg (hwait_cfg),
  .hreadyout (hreadyout),
  .hrdata    (hrdata)
);

// File: tb/sim_ahbw_mem_slave.sv
`timescale 1ns/1ps
module sim_ahbw_mem_slave;

  logic        hclk;
  logic        hresetn;
  logic        hsel;
  logic [31:0] haddr;
  logic [1:0]  htrans;
  logic        hwrite;
  logic [2:0]  hsize;
  logic [2:0]  hburst;
  logic [3:0]  hprot;
  logic        hmastlock;
  logic [31:0] hwdata;
  logic        hready;
  logic [3:0]  hwait_cfg;
  logic [31:0] hrdata;
  logic        hreadyout;
  logic        hresp;
  logic        force_lo;

  int checks;
  int errors;

  logic [31:0] model [64];

  // pending data phase as seen by the bench
  bit          p_v;
  bit          p_w;
  logic [2:0]  p_sz;
  logic [7:0]  p_a;
  logic [31:0] p_wd;
  int          p_wt;
  string       p_tag;

  assign hready = hreadyout && !force_lo;

  ahbw_mem_slave u0 (
    .hclk(hclk), .hresetn(hresetn), .hsel(hsel), .haddr(haddr),
    .htrans(htrans), .hwrite(hwrite), .hsize(hsize), .hburst(hburst),
    .hprot(hprot), .hmastlock(hmastlock), .hwdata(hwdata), .hready(hready),
    .hwait_cfg(hwait_cfg), .hrdata(hrdata), .hreadyout(hreadyout),
    .hresp(hresp)
  );

  initial hclk = 1'b0;
  always #5 hclk = ~hclk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] got,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] merge(input logic [31:0] old,
      input logic [31:0] wd, input logic [2:0] sz, input logic [1:0] off);
    logic [31:0] r;
    r = old;
    case (sz)
      3'b000:  r[8*off +: 8] = wd[8*off +: 8];
      3'b001:  r[16*off[1] +: 16] = wd[16*off[1] +: 16];
      default: r = wd;
    endcase
    return r;
  endfunction

  task automatic xfer(input bit sel, input logic [1:0] tr, input bit wr,
                      input logic [2:0] sz, input logic [7:0] a,
                      input logic [31:0] wd, input int wt, input string tag);
    int n;
    bit moved;
    logic [31:0] first;
    hsel = sel; htrans = tr; hwrite = wr; hsize = sz;
    haddr = {24'h0, a}; hwait_cfg = wt[3:0];
    hburst = 3'($urandom); hprot = 4'($urandom); hmastlock = 1'($urandom);
    hwdata = p_wd;
    n = 0; moved = 0; first = hrdata;
    while (!hreadyout && n < 64) begin
      if (hrdata !== first) moved = 1;
      @(posedge hclk); @(negedge hclk);
      n++;
    end
    if (p_v) begin
      chk(n == p_wt, "R4 R5 R11 stall length", 32'(n), 32'(p_wt));
      if (p_wt != 0) chk(!moved, "R9 read data held", hrdata, first);
      if (p_w) model[p_a[7:2]] = merge(model[p_a[7:2]], p_wd, p_sz, p_a[1:0]);
      else chk(hrdata === model[p_a[7:2]], p_tag, hrdata, model[p_a[7:2]]);
    end else begin
      chk(n == 0, "R2 R3 no stall without transfer", 32'(n), 32'd0);
    end
    chk(hresp == 1'b0, "R10 response OKAY", 32'(hresp), 32'd0);
    p_v = sel && tr[1]; p_w = wr; p_sz = sz; p_a = a; p_wd = wd; p_wt = wt;
    p_tag = tag;
    @(posedge hclk); @(negedge hclk);
  endtask

  task automatic idle();
    xfer(1'b0, 2'b00, 1'b0, 3'b010, 8'h00, 32'h0, 0, "R8");
  endtask

  initial begin
    repeat (200000) @(posedge hclk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    checks = 0; errors = 0; p_v = 0; p_wd = '0; p_tag = "R8";
    force_lo = 0;
    hsel = 0; htrans = 2'b00; hwrite = 0; hsize = 3'b010; haddr = '0;
    hburst = '0; hprot = '0; hmastlock = 0; hwdata = '0; hwait_cfg = '0;
    hresetn = 0;
    repeat (3) @(posedge hclk);
    @(negedge hclk);
    hresetn = 1;
    repeat (3) @(negedge hclk);
    chk(hreadyout == 1'b1, "R1 ready after reset", 32'(hreadyout), 32'd1);
    chk(hresp == 1'b0, "R1 OKAY after reset", 32'(hresp), 32'd0);

    // fill every word, zero wait (R5 R6)
    for (int i = 0; i < 64; i++)
      xfer(1'b1, 2'b10, 1'b1, 3'b010, 8'(i*4), $urandom, 0, "R6");
    idle();

    // word round trip with waits (R6)
    xfer(1'b1, 2'b10, 1'b1, 3'b010, 8'h10, 32'hCAFE_F00D, 3, "R6");
    xfer(1'b1, 2'b10, 1'b0, 3'b010, 8'h10, 32'h0, 2, "R6 word read back");
    idle();

    // byte lanes and halfwords (R7)
    for (int k = 0; k < 4; k++) begin
      xfer(1'b1, 2'b10, 1'b1, 3'b000, 8'(8'h20 + k), 32'h11223344 << k, k, "R7");
      xfer(1'b1, 2'b11, 1'b0, 3'b010, 8'h20, 32'h0, 1, "R7 byte lane");
    end
    for (int h = 0; h < 2; h++) begin
      xfer(1'b1, 2'b10, 1'b1, 3'b001, 8'(8'h24 + 2*h), 32'hA5A5_5A5A ^ h, 2, "R7");
      xfer(1'b1, 2'b10, 1'b0, 3'b000, 8'h25, 32'h0, 0, "R7 halfword lane");
    end
    idle();

    // long stall followed by short one, next address held (R11)
    xfer(1'b1, 2'b10, 1'b1, 3'b010, 8'h40, 32'h0BAD_BEEF, 15, "R11");
    xfer(1'b1, 2'b11, 1'b0, 3'b010, 8'h40, 32'h0, 1, "R11 read after long stall");
    xfer(1'b1, 2'b10, 1'b0, 3'b010, 8'h44, 32'h0, 0, "R11 zero wait after stall");
    idle();

    // deselected, IDLE and BUSY writes leave memory alone (R2 R3)
    xfer(1'b0, 2'b10, 1'b1, 3'b010, 8'h50, 32'hDEAD_0001, 4, "R2");
    xfer(1'b1, 2'b00, 1'b1, 3'b010, 8'h50, 32'hDEAD_0002, 4, "R3");
    xfer(1'b1, 2'b01, 1'b1, 3'b010, 8'h50, 32'hDEAD_0003, 4, "R3");
    xfer(1'b1, 2'b10, 1'b0, 3'b010, 8'h50, 32'h0, 0, "R2 R3 memory unchanged");
    idle();

    // hready low from elsewhere blocks capture (R2)
    hsel = 1; htrans = 2'b10; hwrite = 1; hsize = 3'b010; haddr = 32'h54;
    hwait_cfg = 4'd5; force_lo = 1;
    @(posedge hclk); @(negedge hclk);
    force_lo = 0;
    chk(hreadyout == 1'b1, "R2 no capture while hready low", 32'(hreadyout), 32'd1);
    p_v = 0;
    idle();
    xfer(1'b1, 2'b10, 1'b0, 3'b010, 8'h54, 32'h0, 0, "R2 word intact");
    idle();

    // qualifiers ignored (R12)
    hmastlock = 1;
    xfer(1'b1, 2'b10, 1'b1, 3'b000, 8'h61, 32'h0000_7700, 2, "R12");
    xfer(1'b1, 2'b10, 1'b0, 3'b010, 8'h60, 32'h0, 3, "R12 qualifiers ignored");
    idle();

    // random mix (R4 R6 R7 R8)
    for (int t = 0; t < 600; t++) begin
      bit sel;
      logic [1:0] tr;
      logic [2:0] sz;
      logic [7:0] a;
      int wt;
      sel = ($urandom_range(0, 9) != 0);
      tr  = ($urandom_range(0, 7) == 0) ? 2'($urandom) : {1'b1, 1'($urandom)};
      sz  = 3'($urandom_range(0, 2));
      a   = 8'($urandom);
      a   = (sz == 3'b010) ? {a[7:2], 2'b00} : (sz == 3'b001) ? {a[7:1], 1'b0} : a;
      wt  = ($urandom_range(0, 3) == 0) ? 0 : $urandom_range(0, 15);
      xfer(sel, tr, 1'($urandom), sz, a, $urandom, wt, "R8 random read");
    end
    idle();
    idle();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule